// File: doc/BRIEF.md
# Timestamp Counter with Selectable Tick Rate

This block keeps a free-running timestamp on a 32-bit register bus. Software picks one of three tick rates by writing a configuration word. The first rate is nanoseconds, which advance by the system clock period (20 ns at 50 MHz) on every cycle. The second is microseconds and the third is milliseconds. Both slower rates are paced by a two-stage prescaler that runs off the system clock. Software reads the current value from a read-only count word.

The configuration word holds the rate selector in bits 7:0 and a clear flag in bit 8. The clear flag is held as a level. While it is set, the count is forced to zero and the prescaler is held idle. The usual clearing sequence has two writes: first the current selector with bit 8 set, then the same selector with bit 8 clear. A selector above 2 freezes the count. A read of the count word captures the value in a single cycle, so all 32 bits always come from the same instant.

Top module: `ts_timer`

## Requirements
- R1: After reset the configuration word reads 0 and `bus_rdata_o` is 0.
- R2: A write to address 0x600 stores bits 8:0 of the write data: selector in 7:0, clear flag in 8. A read of 0x600 returns those 9 bits with bits 31:9 zero.
- R3: While the clear flag is 1, the count is 0 at every clock edge.
- R4: With selector 0 and the flag clear, the count grows by CLK_NS (20) on every clock cycle.
- R5: With selector 1, the count grows by 1 once every DIV_US (50) cycles.
- R6: With selector 2, the count grows by 1 once every DIV_US*DIV_MS (50 000) cycles.
- R7: With a selector above 2, the count holds its value.
- R8: The prescaler restarts from zero when a configuration write changes the selector, and it stays at zero while the clear flag is set.
- R9: The count wraps modulo 2^CNT_W. For the default width this means 0xFFFFFFFF is followed by 0.
- R10: A read of address 0x602 returns, on `bus_rdata_o` one cycle later, the count as it stood in the request cycle. A read of any other address returns 0. `bus_rdata_o` holds its value between reads.
- R11: Writes to 0x602 or to any unmapped address leave both the count and the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
Directed sequences cover each rate in turn: per-cycle nanosecond steps, microsecond ticks and a single full millisecond tick. These show whether the step size and the two prescaler stages are right. A second instance with a narrow counter and short dividers covers wrap-around. On that instance, switching the selector partway through a prescaler period shows whether the prescaler restarts on a change. Held clears, invalid selectors and writes to the read-only word each show their freeze or ignore behaviour at the read port. Random mixes of configuration writes, stray writes and reads are compared against a cycle model on every read, which catches ordering faults between a clear, a selector change and a tick.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int DATA_W  = 32;
  localparam int SRC_W   = 8;
  localparam int CFG_W   = SRC_W + 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_NS = 8'd0,
    SRC_US = 8'd1,
    SRC_MS = 8'd2
  } ts_src_e;

  localparam logic [SRC_W-1:0] SRC_MAX = SRC_MS;

  typedef struct packed {
    logic             clr;
    logic [SRC_W-1:0] src;
  } ts_cfg_t;
endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
  parameter int DIV_US = 50,
  parameter int DIV_MS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic us_tick_o,
  output logic ms_tick_o
);
  localparam int US_W = (DIV_US > 1) ? $clog2(DIV_US) : 1;
  localparam int MS_W = (DIV_MS > 1) ? $clog2(DIV_MS) : 1;
  localparam logic [US_W-1:0] US_LAST = US_W'(DIV_US - 1);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(DIV_MS - 1);

  logic [US_W-1:0] us_q;
  logic [MS_W-1:0] ms_q;

  assign us_tick_o = (us_q == US_LAST);
  assign ms_tick_o = us_tick_o && (ms_q == MS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q <= '0;
      ms_q <= '0;
    end else if (clear_i) begin
      us_q <= '0;
      ms_q <= '0;
    end else if (us_tick_o) begin
      us_q <= '0;
      ms_q <= (ms_q == MS_LAST) ? '0 : ms_q + MS_W'(1);
    end else begin
      us_q <= us_q + US_W'(1);
    end
  end

  // R8: a clear leaves both stages at zero
  a_r8_prescale_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (us_q == '0 && ms_q == '0));
  // R5: first stage stays inside its period
  a_r5_us_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    us_q <= US_LAST);
  // R6: a millisecond tick only coincides with a microsecond tick
  a_r6_ms_needs_us: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_tick_o |-> us_tick_o);
endmodule

// File: rtl/ts_accum.sv
module ts_accum
  import ts_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int STEP_NS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ts_cfg_t          cfg_i,
  input  logic             us_tick_i,
  input  logic             ms_tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cfg_i.clr) begin
      cnt_d = '0;
    end else begin
      unique case (cfg_i.src)
        SRC_NS:  cnt_d = cnt_q + STEP;
        SRC_US:  if (us_tick_i) cnt_d = cnt_q + CNT_W'(1);
        SRC_MS:  if (ms_tick_i) cnt_d = cnt_q + CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: held clear forces zero
  a_r3_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.clr |=> cnt_q == '0);
  // R7: invalid selector freezes the count
  a_r7_invalid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.clr && cfg_i.src > SRC_MAX) |=> cnt_q == $past(cnt_q));
  // R4, R9: nanosecond step, modular
  a_r4_ns_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.clr && cfg_i.src == SRC_NS) |=> cnt_q == $past(cnt_q) + STEP);
  // R5: microsecond rate advances at most by one
  a_r5_us_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.clr && cfg_i.src == SRC_US && !us_tick_i) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/ts_regfile.sv
module ts_regfile
  import ts_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h600,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h602
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output ts_cfg_t           cfg_o,
  output logic              src_chg_o,
  output logic [DATA_W-1:0] rdata_o
);
  ts_cfg_t           cfg_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cfg_wr;

  assign cfg_wr    = wr_i && (addr_i == CFG_ADDR);
  assign src_chg_o = cfg_wr && (wdata_i[SRC_W-1:0] != cfg_q.src);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_wr) cfg_q <= ts_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      if (addr_i == CFG_ADDR)      rdata_q <= DATA_W'(cfg_q);
      else if (addr_i == CNT_ADDR) rdata_q <= cnt_i;
      else                         rdata_q <= '0;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = rdata_q;

  // R10: count read is a one-cycle snapshot
  a_r10_read_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == CNT_ADDR) |=> rdata_o == $past(cnt_i));
  // R10: data holds when no read
  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R2: config readback has no stray upper bits
  a_r2_cfg_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == CFG_ADDR) |=> rdata_o[DATA_W-1:CFG_W] == '0);
  // R11: non-config writes leave config alone
  a_r11_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: rtl/ts_timer.sv
module ts_timer
  import ts_pkg::*;
#(
  parameter int                CNT_W    = 32,
  parameter int                CLK_NS   = 20,
  parameter int                DIV_US   = 50,
  parameter int                DIV_MS   = 1000,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h600,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h602
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o
);
  ts_cfg_t           cfg;
  logic              src_chg;
  logic              us_tick, ms_tick;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cnt_ext;

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt};
    end else begin : g_full
      assign cnt_ext = cnt[DATA_W-1:0];
    end
  endgenerate

  ts_regfile #(
    .ADDR_W  (ADDR_W),
    .CFG_ADDR(CFG_ADDR),
    .CNT_ADDR(CNT_ADDR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .cnt_i    (cnt_ext),
    .cfg_o    (cfg),
    .src_chg_o(src_chg),
    .rdata_o  (bus_rdata_o)
  );

  ts_prescaler #(
    .DIV_US(DIV_US),
    .DIV_MS(DIV_MS)
  ) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (src_chg || cfg.clr),
    .us_tick_o(us_tick),
    .ms_tick_o(ms_tick)
  );

  ts_accum #(
    .CNT_W  (CNT_W),
    .STEP_NS(CLK_NS)
  ) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .us_tick_i(us_tick),
    .ms_tick_i(ms_tick),
    .cnt_o    (cnt)
  );

  // R8: selector change restarts the prescaler, so no tick follows at once
  a_r8_chg_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_chg |=> !us_tick || (DIV_US == 1));
endmodule

// File: tb/tb_ts_timer.sv
module tb_ts_model #(
  parameter int CNT_W  = 32,
  parameter int DIV_US = 50,
  parameter int DIV_MS = 1000,
  parameter int STEP   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        rd,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] exp_rd
);
  localparam logic [31:0] MASK = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);
  int unsigned p_us, p_ms;
  logic [7:0]  src;
  logic        clr;
  logic [31:0] cnt;
  logic        t_us, t_ms, chg;

  assign t_us = (p_us == DIV_US - 1);
  assign t_ms = t_us && (p_ms == DIV_MS - 1);
  assign chg  = wr && addr == 12'h600 && wdata[7:0] != src;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_us <= 0; p_ms <= 0; src <= 0; clr <= 0; cnt <= 0; exp_rd <= 0;
    end else begin
      if (rd) exp_rd <= (addr == 12'h600) ? {23'd0, clr, src} :
                        (addr == 12'h602) ? cnt : 32'd0;
      if (clr) cnt <= 0;
      else if (src == 0) cnt <= (cnt + STEP) & MASK;
      else if (src == 1 && t_us) cnt <= (cnt + 1) & MASK;
      else if (src == 2 && t_ms) cnt <= (cnt + 1) & MASK;
      if (chg || clr) begin
        p_us <= 0; p_ms <= 0;
      end else if (t_us) begin
        p_us <= 0;
        p_ms <= (p_ms == DIV_MS - 1) ? 0 : p_ms + 1;
      end else p_us <= p_us + 1;
      if (wr && addr == 12'h600) {clr, src} <= wdata[8:0];
    end
  end
endmodule

module tb_ts_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_big, rd_small, exp_big, exp_small;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam logic [11:0] A_CFG = 12'h600;
  localparam logic [11:0] A_CNT = 12'h602;

  always #5 clk = ~clk;

  ts_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_big));

  ts_timer #(.CNT_W(12), .DIV_US(5), .DIV_MS(4)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_small));

  tb_ts_model m_big (.clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr),
                     .wdata(wdata), .exp_rd(exp_big));
  tb_ts_model #(.CNT_W(12), .DIV_US(5), .DIV_MS(4)) m_small (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata), .exp_rd(exp_small));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(logic [11:0] a, string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    check({tag, " main"}, rd_big, exp_big);
    check({tag, " small"}, rd_small, exp_small);
  endtask

  initial begin
    logic [31:0] first;
    void'($urandom(32'h5EED_1234));
    idle(3);
    // R1: reset state
    check("R1 rdata after reset", rd_big, 32'd0);
    rst_n = 1'b1;
    bus_read(A_CFG, "R1 cfg after reset");
    check("R1 cfg literal", rd_big, 32'd0);

    // R2: upper write bits dropped
    bus_write(A_CFG, 32'hABCD_0102);
    bus_read(A_CFG, "R2 cfg readback");
    check("R2 cfg literal", rd_big, 32'h0000_0102);

    // R3: held clear
    idle(30);
    bus_read(A_CNT, "R3 held clear");
    check("R3 zero literal", rd_big, 32'd0);

    // R4: nanosecond rate
    bus_write(A_CFG, 32'h0000_0000);
    idle(17);
    bus_read(A_CNT, "R4 ns rate");
    check("R4 multiple of 20", rd_big % 20, 32'd0);

    // R5: microsecond rate
    bus_write(A_CFG, 32'h100); bus_write(A_CFG, 32'h1);
    idle(520);
    bus_read(A_CNT, "R5 us rate");
    check("R5 about ten us", rd_big, 32'd10);

    // R7: invalid selector holds
    bus_write(A_CFG, 32'h3);
    bus_read(A_CNT, "R7 before");
    first = rd_big;
    idle(200);
    bus_read(A_CNT, "R7 after");
    check("R7 unchanged", rd_big, first);

    // R11: stray writes ignored
    bus_write(A_CNT, 32'hFFFF_FFFF);
    bus_write(12'h123, 32'h1FF);
    bus_read(A_CNT, "R11 count after stray writes");
    check("R11 count literal", rd_big, first);
    bus_read(A_CFG, "R11 cfg after stray writes");
    check("R11 cfg literal", rd_big, 32'h3);
    bus_read(12'h7FF, "R10 unmapped read");
    check("R10 unmapped zero", rd_big, 32'd0);

    // R8: selector switch mid-period restarts prescaler (small instance)
    bus_write(A_CFG, 32'h1);
    idle(3);
    bus_write(A_CFG, 32'h2);
    idle(2);
    bus_write(A_CFG, 32'h1);
    idle(4);
    bus_read(A_CNT, "R8 restart after switch");

    // R9: wrap on 12-bit instance
    bus_write(A_CFG, 32'h100); bus_write(A_CFG, 32'h0);
    idle(300);
    bus_read(A_CNT, "R9 wrap");

    // R6: one millisecond tick on the main instance
    bus_write(A_CFG, 32'h100); bus_write(A_CFG, 32'h2);
    idle(50_100);
    bus_read(A_CNT, "R6 ms rate");
    check("R6 one ms", rd_big, 32'd1);

    // R10: random mix against the model
    for (int i = 0; i < 2500; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 3)
        bus_write(A_CFG, {23'd0, ($urandom % 8) == 0, 8'($urandom % 5)});
      else if (r < 4)
        bus_write((($urandom % 2) == 0) ? A_CNT : 12'($urandom), $urandom);
      else if (r < 6)
        bus_read(A_CFG, "R2 random cfg");
      else if (r < 9)
        bus_read(A_CNT, "R10 random count");
      else
        bus_read(12'($urandom), "R10 random addr");
      idle($urandom % 20);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule